// File: doc/BRIEF.md
# Timer Channel with Capture, Compare and PWM

This block is one channel of a timer. It watches a shared free-running counter and, under control of a small status/control register, does one of four jobs. It can latch the counter on a pin edge (input capture). It can act on the pin when the counter equals a programmed value (output compare). It can also drive an edge-aligned or a center-aligned pulse-width waveform. A global center-aligned select, shared by all channels, chooses between the two PWM styles. The counter, its prescaler and the address decoding sit outside the block. The block receives the counter value, a one-cycle `cnt_tick` strobe for each new count and a down-count indication.

Software reads the register and the 16-bit value register over a simple read/write port. Each capture, compare match or PWM match sets an event flag. Software clears the flag in two steps: it reads the register while the flag is set, then writes a zero to the flag bit. An event that arrives between those two steps defeats the clear, so no event is lost. The interrupt request is the flag gated by an enable bit. The channel reads new mode and edge bits only at the start of a counter period, so a mode change never cuts a waveform in half.

Top module: `tmr_chan`

## Requirements
- R1: The control register sits at address 0 and reads as {flag[7], irq enable[6], mode[5:4], edge[3:2], 2'b00}. It resets to all zeros. The value register sits at address 1 and is the value that captures load and that compares and PWM match against.
- R2: With center select 0 and mode 00, the channel is in input capture. Edge 01 captures on rising pin edges only, edge 10 on falling edges only, edge 11 on both. A capture loads the counter value into the value register.
- R3: With center select 0 and mode 01, a match (a tick with counter == value) does one of three things to the pin. Edge 01 toggles it, edge 10 drives it low, edge 11 drives it high. The pin output changes only on cycles with a counter tick.
- R4: With center select 0 and mode 1x, edge-aligned PWM runs. With edge 10, a match drives the pin low and a tick at count 0 drives it high. With edge x1 the levels are inverted.
- R5: With center select 1 and edge 10, a match while counting up drives the pin low and a match while counting down drives it high. With edge x1 the levels are inverted.
- R6: The pin enable is low when the active edge bits are 00 and also in input capture. It is high in compare and in both PWM modes.
- R7: Every capture, compare match or PWM match sets the flag. A disabled channel (edge 00) sets no flag.
- R8: A write with bit 7 = 0 clears the flag only after a read of the control register made while the flag was set. Writing 1 to bit 7 never sets it, and a zero write without that prior read leaves it set.
- R9: An event between the qualifying read and the zero write cancels the clear. The flag stays set until another read and write.
- R10: The interrupt request is high exactly while both the flag and the enable bit are set.
- R11: New mode, edge and center-select values take effect only at a tick with counter == 0. Until then the previous configuration keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | W | Shared counter value |
| cnt_tick | input | 1 | One-cycle strobe: counter holds a new value |
| cnt_down | input | 1 | Counter is counting down (center-aligned) |
| ctr_sel | input | 1 | Global center-aligned PWM select |
| pin_in | input | 1 | Channel pin input (asynchronous) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = control register, 1 = value register |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for the addressed register |
| pin_out | output | 1 | Channel pin output level |
| pin_oe | output | 1 | Channel drives the pin |
| cap_val | output | W | Value register (captured or programmed value) |
| irq | output | 1 | Interrupt request (level) |

## Verification
Compare mode is driven with ticks at count 0, at a non-matching count and repeatedly at the match value. This separates toggle, clear and set, and shows that non-matching ticks and bus traffic leave the pin unchanged. Capture is tried with a rising pulse and a falling pulse in each edge setting while the counter is held at a different value each time, so a missed edge and a wrongly taken edge both show up in the value read back. PWM is driven with up and down matches and count-0 wraps in both polarities. The flag is probed by a zero write without a read, by a read followed by an event before the write, and by a proper read-then-write, which tells the three clear outcomes apart.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         cnt_tick,
  input  logic         cnt_down,
  input  logic         ctr_sel,
  input  logic         pin_in,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic         bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         pin_out,
  output logic         pin_oe,
  output logic [W-1:0] cap_val,
  output logic         irq
);

  typedef enum logic [2:0] {M_OFF, M_CAP, M_CMP, M_EPWM, M_CPWM} mode_t;

  logic         flag, ie, arm;
  logic [1:0]   ms, els;
  logic [1:0]   e_ms, e_els;
  logic         e_cpw;
  logic [W-1:0] val;
  logic         pin_q, pin_qq;
  mode_t        mode;

  logic wrap, hit, rise, fall, cap_evt, evt, ctl_wr, ctl_rd, clr_ok;

  assign wrap   = cnt_tick && (cnt == '0);
  assign hit    = cnt_tick && (cnt == val);
  assign rise   = pin_q & ~pin_qq;
  assign fall   = ~pin_q & pin_qq;
  assign ctl_wr = bus_wr && !bus_addr;
  assign ctl_rd = bus_rd && !bus_addr;

  always_comb begin
    if (e_els == 2'b00)    mode = M_OFF;
    else if (e_cpw)        mode = M_CPWM;
    else if (e_ms == 2'b00) mode = M_CAP;
    else if (e_ms == 2'b01) mode = M_CMP;
    else                   mode = M_EPWM;
  end

  assign cap_evt = (mode == M_CAP) && ((e_els[0] && rise) || (e_els[1] && fall));
  assign evt     = cap_evt || (hit && (mode == M_CMP || mode == M_EPWM || mode == M_CPWM));
  assign clr_ok  = ctl_wr && !bus_wdata[7] && arm && !evt;

  assign pin_oe    = (mode == M_CMP) || (mode == M_EPWM) || (mode == M_CPWM);
  assign irq       = flag & ie;
  assign cap_val   = val;
  assign bus_rdata = bus_addr ? val : {{(W-8){1'b0}}, flag, ie, ms, els, 2'b00};

  // pin input: one sampling stage plus a history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      pin_qq <= 1'b0;
    end else begin
      pin_q  <= pin_in;
      pin_qq <= pin_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie  <= 1'b0;
      ms  <= 2'b00;
      els <= 2'b00;
    end else if (ctl_wr) begin
      ie  <= bus_wdata[6];
      ms  <= bus_wdata[5:4];
      els <= bus_wdata[3:2];
    end
  end

  // configuration in use, refreshed at the period start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_ms  <= 2'b00;
      e_els <= 2'b00;
      e_cpw <= 1'b0;
    end else if (wrap) begin
      e_ms  <= ms;
      e_els <= els;
      e_cpw <= ctr_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      arm  <= 1'b0;
    end else begin
      flag <= evt | (flag & ~clr_ok);
      if (evt || ctl_wr)      arm <= 1'b0;
      else if (ctl_rd && flag) arm <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  val <= '0;
    else if (cap_evt)            val <= cnt;
    else if (bus_wr && bus_addr) val <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_out <= 1'b0;
    else begin
      case (mode)
        M_CMP:
          if (hit) begin
            case (e_els)
              2'b01:   pin_out <= ~pin_out;
              2'b10:   pin_out <= 1'b0;
              default: pin_out <= 1'b1;
            endcase
          end
        M_EPWM:
          if (hit)       pin_out <= e_els[0];
          else if (wrap) pin_out <= ~e_els[0];
        M_CPWM:
          if (hit) pin_out <= cnt_down ? ~e_els[0] : e_els[0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic         cnt_tick,
  input logic         bus_wr,
  input logic         bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic         pin_out,
  input logic [W-1:0] cap_val,
  input logic         flag,
  input logic         evt,
  input logic         cap_evt,
  input logic [1:0]   e_ms,
  input logic [1:0]   e_els,
  input logic         e_cpw
);

  // R7
  evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(bus_wr && !bus_addr && !bus_wdata[7]));

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_tick && cnt == '0) |=> $stable({e_cpw, e_ms, e_els}));

  // R3
  pin_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(pin_out));

  // R2
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && bus_addr) && !cap_evt) |=> $stable(cap_val));

endmodule

bind tmr_chan tmr_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_tick(cnt_tick),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pin_out(pin_out), .cap_val(cap_val), .flag(flag), .evt(evt),
  .cap_evt(cap_evt), .e_ms(e_ms), .e_els(e_els), .e_cpw(e_cpw)
);

// File: tb/sim_tmr_chan.sv
`timescale 1ns/1ps
module sim_tmr_chan;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic cnt_tick = 1'b0, cnt_down = 1'b0, ctr_sel = 1'b0, pin_in = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata, cap_val;
  logic pin_out, pin_oe, irq;

  always #4 clk = ~clk;

  tmr_chan #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_tick(cnt_tick), .cnt_down(cnt_down),
    .ctr_sel(ctr_sel), .pin_in(pin_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .cap_val(cap_val), .irq(irq)
  );

  typedef struct { string req; int kind; logic [W-1:0] exp; } item_t;
  item_t q[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  // kinds: 0 read data, 1 pin_out, 2 pin_oe, 3 irq
  task automatic want(input string req, input int kind, input logic [W-1:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [W-1:0] obs;
      it = q.pop_front();
      case (it.kind)
        0: obs = bus_rdata;
        1: obs = {{(W-1){1'b0}}, pin_out};
        2: obs = {{(W-1){1'b0}}, pin_oe};
        default: obs = {{(W-1){1'b0}}, irq};
      endcase
      total++;
      if (obs !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, obs, it.exp);
      end
    end
  end

  task automatic wr(input logic a, input logic [W-1:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rdchk(input logic a, input logic [W-1:0] exp, input string req);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; want(req, 0, exp);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tk(input logic [W-1:0] c, input logic dn);
    @(negedge clk); cnt = c; cnt_down = dn; cnt_tick = 1'b1;
    @(negedge clk); cnt_tick = 1'b0;
  endtask

  task automatic edge_to(input logic [W-1:0] c, input logic lvl);
    @(negedge clk); cnt = c; pin_in = lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    want("R1 reset ctrl", 0, 16'h0000);
    want("R6 reset oe", 2, 0);
    want("R10 reset irq", 3, 0);
    want("R3 reset pin", 1, 0);

    wr(0, 16'h00FF);
    rdchk(0, 16'h007C, "R1 R8 layout, flag not writable as 1");
    wr(0, 16'h0000);
    wr(1, 16'd5);
    rdchk(1, 16'd5, "R1 value reg");

    // compare toggle
    wr(0, 16'h0014);
    tk(5, 0);
    want("R11 old mode kept", 1, 0);
    rdchk(0, 16'h0014, "R11 no event before period");
    tk(0, 0);
    want("R6 compare oe", 2, 1);
    tk(3, 0);
    want("R3 no match", 1, 0);
    tk(5, 0);
    want("R3 toggle", 1, 1);
    wr(0, 16'h0014);
    rdchk(0, 16'h0094, "R8 write without read");
    wr(0, 16'h0014);
    rdchk(0, 16'h0014, "R8 read then write clears");
    tk(5, 0);
    want("R3 toggle back", 1, 0);
    rdchk(0, 16'h0094, "R7 compare flag");
    tk(5, 0);
    wr(0, 16'h0014);
    rdchk(0, 16'h0094, "R9 event between read and write");
    wr(0, 16'h0014);
    rdchk(0, 16'h0014, "R9 later clear");

    // interrupt
    wr(0, 16'h0054);
    want("R10 no flag", 3, 0);
    tk(5, 0);
    want("R10 irq on", 3, 1);
    rdchk(0, 16'h00D4, "R10 ctrl");
    wr(0, 16'h0054);
    want("R10 irq off", 3, 0);

    // compare set / clear with deferred change
    wr(0, 16'h001C);
    tk(0, 0);
    tk(5, 0);
    want("R3 set", 1, 1);
    wr(0, 16'h0018);
    tk(5, 0);
    want("R11 set still active", 1, 1);
    tk(0, 0);
    tk(5, 0);
    want("R3 clear", 1, 0);

    // edge-aligned PWM
    wr(0, 16'h0028);
    tk(0, 0);
    tk(0, 0);
    want("R4 high-true wrap", 1, 1);
    tk(3, 0);
    want("R4 mid period", 1, 1);
    tk(5, 0);
    want("R4 high-true match", 1, 0);
    tk(0, 0);
    wr(0, 16'h0024);
    tk(0, 0);
    tk(0, 0);
    want("R4 low-true wrap", 1, 0);
    tk(5, 0);
    want("R4 low-true match", 1, 1);

    // center-aligned PWM
    @(negedge clk); ctr_sel = 1'b1;
    wr(0, 16'h0028);
    tk(0, 0);
    want("R6 center oe", 2, 1);
    tk(5, 1);
    want("R5 high-true down", 1, 1);
    tk(5, 0);
    want("R5 high-true up", 1, 0);
    wr(0, 16'h0024);
    tk(0, 0);
    tk(5, 0);
    want("R5 low-true up", 1, 1);
    tk(5, 1);
    want("R5 low-true down", 1, 0);

    // input capture
    @(negedge clk); ctr_sel = 1'b0;
    rdchk(0, 16'h00A4, "R7 PWM flag");
    wr(0, 16'h0004);
    tk(0, 0);
    want("R6 capture oe", 2, 0);
    rdchk(0, 16'h0004, "R8 clear before capture");
    edge_to(16'h0033, 1'b1);
    rdchk(1, 16'h0033, "R2 rising captured");
    rdchk(0, 16'h0084, "R7 capture flag");
    wr(0, 16'h0004);
    edge_to(16'h003A, 1'b0);
    rdchk(1, 16'h0033, "R2 falling ignored");
    rdchk(0, 16'h0004, "R2 no flag on falling");
    wr(0, 16'h0008);
    tk(0, 0);
    edge_to(16'h0044, 1'b1);
    rdchk(1, 16'h0033, "R2 rising ignored");
    edge_to(16'h0045, 1'b0);
    rdchk(1, 16'h0045, "R2 falling captured");
    wr(0, 16'h000C);
    tk(0, 0);
    edge_to(16'h0055, 1'b1);
    rdchk(1, 16'h0055, "R2 both rising");
    edge_to(16'h0066, 1'b0);
    rdchk(1, 16'h0066, "R2 both falling");

    // disabled
    rdchk(0, 16'h008C, "R7 flag before disable");
    wr(0, 16'h0000);
    tk(0, 0);
    want("R6 disabled oe", 2, 0);
    wr(1, 16'd5);
    tk(5, 0);
    rdchk(0, 16'h0000, "R7 no event when off");
    want("R3 pin held when off", 1, 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule